// File: doc/BRIEF.md
# Dual-Path Round and Bit-Window Output Stage

This block takes two 32-bit filter-half results, A and B, and turns them into 16-bit output words. In combined mode it adds the two halves into one result. It can double B before the sum, which supports wider data or coefficient formats. In split mode the halves stay apart as two results. Each result then gets a rounding constant added to it. The constant comes from one of sixteen programmable 32-bit registers per path, and the register is chosen on every accepted sample. A per-path bit window then picks 16 contiguous bits of the rounded word.

Samples enter and leave through valid/ready handshakes. A sample moves only when it is accepted (`in_valid` and `in_ready` both high). A word that has been presented stays on the output while `out_ready` is low. While the output is stalled, `in_ready` drops and nothing inside the block moves. A simple write port loads the rounding and window registers. Mode, doubling and the four per-sample index inputs are plain control pins. They are sampled together with the data they apply to.

Top module: `dual_round_select`

## Requirements
- R1: In combined mode (`dual_mode`=0), `out_a` = bits of (A + B + roundA[`rnd_sel_a`]) modulo 2^32, taken through window A[`win_sel_a`], and `out_b` = 0.
- R2: In combined mode with `scale_b`=1, B is shifted left by one bit (modulo 2^32) before the sum. In split mode `scale_b` has no effect.
- R3: In split mode (`dual_mode`=1), `out_a` comes from A + roundA[`rnd_sel_a`] and `out_b` comes from B + roundB[`rnd_sel_b`]. Each result goes through its own window: A[`win_sel_a`] or B[`win_sel_b`].
- R4: A round select of n adds round register n of that path. The selects may differ on every accepted sample. In combined mode `rnd_sel_b` has no effect.
- R5: A round register that holds 0 leaves the result unrounded.
- R6: A window register holding k makes the output equal bits [k+15:k] of the rounded word. Written values above 16 are stored as 16.
- R7: A write (`wr_en`=1) targets bank `wr_addr[4]` (0 = A, 1 = B) and index `wr_addr[3:0]`. `wr_kind` 0 targets the round register and `wr_kind` 1 targets the window register. A sample accepted in the same cycle as the write still sees the old value. A sample accepted in the next cycle sees the new value.
- R8: A sample accepted at clock edge N is on the output with `out_valid`=1 after edge N+2, as long as the output is not stalled.
- R9: While `out_valid`=1 and `out_ready`=0, `out_a`, `out_b` and `out_valid` hold and `in_ready`=0. No accepted sample is lost or duplicated.
- R10: Synchronous reset clears `out_valid`, `out_a`, `out_b`, all round registers and all window registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_a | input | 32 | Filter half A result |
| in_b | input | 32 | Filter half B result |
| rnd_sel_a | input | 4 | Round register index, path A |
| rnd_sel_b | input | 4 | Round register index, path B |
| win_sel_a | input | 4 | Window register index, path A |
| win_sel_b | input | 4 | Window register index, path B |
| dual_mode | input | 1 | 1 = split results, 0 = combined |
| scale_b | input | 1 | Double B before the sum in combined mode |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 1 | 0 = round register, 1 = window register |
| wr_addr | input | 5 | Bank bit [4], index [3:0] |
| wr_data | input | 32 | Write data |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output |
| out_a | output | 16 | Windowed result A (or combined result) |
| out_b | output | 16 | Windowed result B, zero in combined mode |

## Verification
The bench targets several corner cases:
- **Sum overflow.** Both 32-bit sum overflows wrap to small results. A design that saturated, or that kept a carry, would show a wrong low word.
- **Window edges.** Window values 0 and 16 are exercised, along with a written value above 16. An off-by-one or an unclamped shift would move the extracted window.
- **Same-cycle write.** A write and a sample arrive in the same cycle. This exposes a bypass that applies the new round value one sample too early.
- **Per-sample select changes and stalls.** Round selects alternate on consecutive samples, and the output stalls while the input is still pushing. A design that latched selects late, or that let data advance under a stall, would lose, repeat or misround words.
- **Reset.** Reset is asserted mid-stream, then rounding is checked afterwards. This catches registers that survive reset.

// File: rtl/dual_round_select_pkg.sv
package dual_round_select_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned OUT_W    = 16;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned NREG     = 1 << IDX_W;
  localparam int unsigned SHIFT_MAX = WORD_W - OUT_W;
  localparam int unsigned SHIFT_W  = $clog2(SHIFT_MAX + 1);
  localparam int unsigned NPATH    = 2;

  typedef enum logic {KIND_ROUND = 1'b0, KIND_WINDOW = 1'b1} reg_kind_e;

  typedef struct packed {
    logic [WORD_W-1:0]  word;
    logic [SHIFT_W-1:0] shift;
  } path_stage_t;
endpackage

// File: rtl/dual_round_select_bank.sv
module dual_round_select_bank
  import dual_round_select_pkg::*;
#(
  parameter int unsigned P_WORD_W  = WORD_W,
  parameter int unsigned P_IDX_W   = IDX_W,
  parameter int unsigned P_SHIFT_W = SHIFT_W,
  parameter int unsigned P_SHIFT_MAX = SHIFT_MAX
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_kind,
  input  logic [P_IDX_W-1:0]   wr_idx,
  input  logic [P_WORD_W-1:0]  wr_data,
  input  logic [P_IDX_W-1:0]   rnd_idx,
  input  logic [P_IDX_W-1:0]   win_idx,
  output logic [P_WORD_W-1:0]  rnd_val,
  output logic [P_SHIFT_W-1:0] win_val
);
  localparam int unsigned DEPTH = 1 << P_IDX_W;

  logic [P_WORD_W-1:0]  rnd_q [DEPTH];
  logic [P_SHIFT_W-1:0] win_q [DEPTH];
  logic [P_SHIFT_W-1:0] win_clamped;

  always_comb begin
    if (wr_data > P_WORD_W'(P_SHIFT_MAX)) win_clamped = P_SHIFT_W'(P_SHIFT_MAX);
    else                                   win_clamped = wr_data[P_SHIFT_W-1:0];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        rnd_q[i] <= '0;
        win_q[i] <= '0;
      end else if (wr_en && wr_idx == P_IDX_W'(i)) begin
        if (wr_kind == KIND_WINDOW) win_q[i] <= win_clamped;
        else                        rnd_q[i] <= wr_data;
      end
    end
  end

  assign rnd_val = rnd_q[rnd_idx];
  assign win_val = win_q[win_idx];
endmodule

// File: rtl/dual_round_select_window.sv
module dual_round_select_window
  import dual_round_select_pkg::*;
#(
  parameter int unsigned P_WORD_W  = WORD_W,
  parameter int unsigned P_OUT_W   = OUT_W,
  parameter int unsigned P_SHIFT_W = SHIFT_W
) (
  input  logic [P_WORD_W-1:0]  word,
  input  logic [P_SHIFT_W-1:0] shift,
  output logic [P_OUT_W-1:0]   slice
);
  assign slice = word[shift +: P_OUT_W];
endmodule

// File: rtl/dual_round_select.sv
module dual_round_select
  import dual_round_select_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [31:0]  in_a,
  input  logic [31:0]  in_b,
  input  logic [3:0]   rnd_sel_a,
  input  logic [3:0]   rnd_sel_b,
  input  logic [3:0]   win_sel_a,
  input  logic [3:0]   win_sel_b,
  input  logic         dual_mode,
  input  logic         scale_b,
  input  logic         wr_en,
  input  logic         wr_kind,
  input  logic [4:0]   wr_addr,
  input  logic [31:0]  wr_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [15:0]  out_a,
  output logic [15:0]  out_b
);
  logic                advance;
  logic                s1_valid;
  logic [WORD_W-1:0]   path_in   [NPATH];
  logic [IDX_W-1:0]    rnd_sel   [NPATH];
  logic [IDX_W-1:0]    win_sel   [NPATH];
  logic [WORD_W-1:0]   rnd_val   [NPATH];
  logic [SHIFT_W-1:0]  win_val   [NPATH];
  logic [WORD_W-1:0]   rounded   [NPATH];
  path_stage_t         s1_q      [NPATH];
  logic [OUT_W-1:0]    slice     [NPATH];
  logic [OUT_W-1:0]    out_q     [NPATH];
  logic [WORD_W-1:0]   b_term;

  // Whole pipeline moves together; it freezes only when a presented word waits.
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  assign b_term = scale_b ? {in_b[WORD_W-2:0], 1'b0} : in_b;

  // Path 0 carries the combined result in combined mode.
  assign path_in[0] = dual_mode ? in_a : in_a + b_term;
  assign path_in[1] = in_b;
  assign rnd_sel[0] = rnd_sel_a;
  assign rnd_sel[1] = rnd_sel_b;
  assign win_sel[0] = win_sel_a;
  assign win_sel[1] = win_sel_b;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    dual_round_select_bank u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en && (wr_addr[IDX_W] == 1'(p))),
      .wr_kind (wr_kind),
      .wr_idx  (wr_addr[IDX_W-1:0]),
      .wr_data (wr_data),
      .rnd_idx (rnd_sel[p]),
      .win_idx (win_sel[p]),
      .rnd_val (rnd_val[p]),
      .win_val (win_val[p])
    );

    if (p == 0) begin : g_main
      assign rounded[p] = path_in[p] + rnd_val[p];
    end else begin : g_aux
      assign rounded[p] = dual_mode ? path_in[p] + rnd_val[p] : '0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q[p] <= '0;
      end else if (advance) begin
        s1_q[p].word  <= rounded[p];
        s1_q[p].shift <= win_val[p];
      end
    end

    dual_round_select_window u_win (
      .word  (s1_q[p].word),
      .shift (s1_q[p].shift),
      .slice (slice[p])
    );

    always_ff @(posedge clk) begin
      if (rst)          out_q[p] <= '0;
      else if (advance) out_q[p] <= slice[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else if (advance) begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
    end
  end

  assign out_a = out_q[0];
  assign out_b = out_q[1];
endmodule

// File: rtl/dual_round_select_chk.sv
module dual_round_select_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        s1_valid,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_a,
  input logic [15:0] out_b
);
  // R10: first cycle out of reset shows a cleared output
  assert_reset_clear_R10: assert property (@(posedge clk)
    $past(rst) && !rst |-> !out_valid && out_a == 16'h0 && out_b == 16'h0);

  // R9: a stalled word holds
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_a) && $stable(out_b));

  // R9: no intake while stalled
  assert_stall_block_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R8: first pipeline step
  assert_latency_s1_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> s1_valid);

  // R8: second pipeline step
  assert_latency_s2_R8: assert property (@(posedge clk) disable iff (rst)
    s1_valid && in_ready |=> out_valid);
endmodule

bind dual_round_select dual_round_select_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .s1_valid  (s1_valid),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_a     (out_a),
  .out_b     (out_b)
);

// File: tb/dual_round_select_tb.sv
`timescale 1ns/1ps
module dual_round_select_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [31:0] in_a, in_b;
  logic [3:0]  rnd_sel_a, rnd_sel_b, win_sel_a, win_sel_b;
  logic        dual_mode, scale_b;
  logic        wr_en, wr_kind;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic        out_valid, out_ready;
  logic [15:0] out_a, out_b;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  dual_round_select u_dut (.*);

  // {dual, scale, a, b, rsa, rsb, wsa, wsb, exp_a, exp_b}
  // Programmed: roundA[n]=n<<8, roundB[n]=n<<12, winA[n]=n, winB[n]=16-n
  localparam int NV = 6;
  localparam logic [113:0] VEC [NV] = '{
    {1'b0,1'b0,32'h0001_2345,32'h0000_1111,4'd0,4'd0,4'd0,4'd0,16'h3456,16'h0000},
    {1'b0,1'b1,32'h0001_0000,32'h0000_8000,4'd1,4'd0,4'd4,4'd0,16'h2010,16'h0000},
    {1'b0,1'b0,32'hFFFF_FFFF,32'h0000_0002,4'd0,4'd0,4'd0,4'd0,16'h0001,16'h0000},
    {1'b1,1'b0,32'h1234_0000,32'hABCD_0000,4'd2,4'd1,4'd8,4'd0,16'h3402,16'hABCD},
    {1'b1,1'b1,32'h0000_00FF,32'h0000_0100,4'd0,4'd0,4'd0,4'd8,16'h00FF,16'h0001},
    {1'b0,1'b1,32'h8000_0000,32'h4000_0000,4'd3,4'd15,4'd0,4'd0,16'h0300,16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic kind, input logic [4:0] addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input logic dm, input logic sc, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] ra, input logic [3:0] rb, input logic [3:0] wa, input logic [3:0] wb);
    in_valid = 1'b1; dual_mode = dm; scale_b = sc; in_a = a; in_b = b;
    rnd_sel_a = ra; rnd_sel_b = rb; win_sel_a = wa; win_sel_b = wb;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; wr_en = 1'b0; wr_kind = 1'b0;
    wr_addr = '0; wr_data = '0; drive(1'b0, 1'b0, 0, 0, 0, 0, 0, 0); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", 32'(out_valid), 0);
    chk("R10 reset out_a", 32'(out_a), 0);
    rst = 1'b0;

    for (int n = 0; n < 16; n++) begin
      wr(1'b0, {1'b0, 4'(n)}, 32'(n) << 8);
      wr(1'b0, {1'b1, 4'(n)}, 32'(n) << 12);
      wr(1'b1, {1'b0, 4'(n)}, 32'(n));
      wr(1'b1, {1'b1, 4'(n)}, 32'(16 - n));
    end

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(VEC[v][113], VEC[v][112], VEC[v][111:80], VEC[v][79:48],
            VEC[v][47:44], VEC[v][43:40], VEC[v][39:36], VEC[v][35:32]);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk($sformatf("R8 vec%0d valid", v), 32'(out_valid), 1);
      chk($sformatf("R1/R3 vec%0d out_a", v), 32'(out_a), 32'(VEC[v][31:16]));
      chk($sformatf("R3 vec%0d out_b", v), 32'(out_b), 32'(VEC[v][15:0]));
    end

    // R6 clamp: window A[2] written with 20 acts as 16
    wr(1'b1, 5'd2, 32'd20);
    @(negedge clk);
    drive(1'b0, 1'b0, 32'h5678_0000, 0, 0, 0, 4'd2, 0);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk("R6 clamp above 16", 32'(out_a), 32'h5678);

    // R7 write timing: same-cycle sample sees old roundA[5]=0x500
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 1'b0; wr_addr = 5'd5; wr_data = 32'h7;
    drive(1'b0, 1'b0, 32'h10, 0, 4'd5, 0, 0, 0);
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    chk("R7 same-cycle old value", 32'(out_a), 32'h0510);
    chk("R7 next-cycle new value pipelined", 32'(out_valid), 1);
    @(negedge clk); in_valid = 1'b0;
    chk("R7 next-cycle new value", 32'(out_a), 32'h0017);
    @(negedge clk);

    // R4/R8 streaming with alternating round selects
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        chk($sformatf("R4 stream %0d", j - 2), 32'(out_a),
            32'((32'h1000 * (j - 2)) + (((j - 2) % 2) ? 32'h200 : 32'h100)));
      end
      if (j < 4) drive(1'b0, 1'b0, 32'h1000 * j, 0, (j % 2) ? 4'd2 : 4'd1, 0, 0, 0);
      else in_valid = 1'b0;
    end

    // R9 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(1'b1, 1'b0, 32'h0000_1111, 32'h0000_2222, 0, 0, 0, 4'd0);
    @(negedge clk);
    drive(1'b1, 1'b0, 32'h0000_3333, 32'h0000_4444, 0, 0, 0, 4'd0);
    @(negedge clk);
    in_valid = 1'b0;
    for (int h = 0; h < 3; h++) begin
      chk("R9 in_ready low", 32'(in_ready), 0);
      chk("R9 hold out_a", 32'(out_a), 32'h1111);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 next word out_a", 32'(out_a), 32'h3333);
    chk("R9 next word valid", 32'(out_valid), 1);
    @(negedge clk);
    chk("R9 no duplicate", 32'(out_valid), 0);

    // R10 reset mid-stream clears registers
    drive(1'b0, 1'b0, 32'hAAAA, 0, 4'd5, 0, 4'd4, 0);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R10 mid reset valid", 32'(out_valid), 0);
    chk("R10 mid reset out_b", 32'(out_b), 0);
    rst = 1'b0;
    drive(1'b0, 1'b0, 32'h0001_2345, 0, 4'd5, 0, 4'd4, 0);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk("R10 round and window cleared", 32'(out_a), 32'h2345);

    summary();
    $finish;
  end
endmodule